// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter Chain

This block is a wide synchronous up-counter built from identical 4-bit counter stages. Every stage can be preset, and one clock drives all of them, so all count bits change on the same rising edge. Each stage has two count enables.

- `run_en` is shared by every stage.
- `chain_en` enters the lowest stage only. Each stage then passes a carry signal to the next stage above it. That carry is high when the stage holds all ones and its own chain enable is high.

A stage counts only when both of its enables are high. Only the chain enable reaches the carry. The carry is combinational, so a higher stage learns in the same cycle that the stages below it are about to overflow. No extra gating is needed between stages.

The counter has three controls, in order of priority:

- An active-low asynchronous clear empties the whole counter at once.
- An active-low synchronous load copies a parallel value into the counter at the next edge, whatever the enables are.
- Otherwise the counter either increments or holds.

When the `MOD_EN` parameter is set, a small modulo controller sits in front of the stages. It watches for a terminal value. When the counter is counting and reaches that value, the controller forces a load of a preset value, so the counter runs through a fixed range.

Top module: `cnt_chain`

## Requirements
- R1: While `wipe_n` is low, `count` is zero at once, without waiting for a clock edge. It stays zero on every edge while `wipe_n` remains low, whatever the levels of load and the enables.
- R2: With `wipe_n` high and `load_n` low, the rising edge puts `load_val` into `count`, whatever the levels of `run_en` and `chain_en`.
- R3: With `load_n`, `run_en` and `chain_en` all high, each rising edge adds one to `count`, modulo 2^WIDTH. The modulo terminal case of R10 is the exception.
- R4: With `load_n` high and either enable low, `count` keeps its value across the edge.
- R5: `carry_out` is high exactly when `chain_en` is high and every bit of `count` is one.
- R6: `run_en` has no influence on `carry_out`. With `count` all ones and `chain_en` high, `carry_out` stays high while `run_en` is low.
- R7: Changing `load_n`, `load_val`, `run_en` or `chain_en` between edges leaves `count` unchanged until the next rising edge. Only the levels present at that edge decide the operation.
- R8: Stages are cascaded. A stage advances only on an edge where every stage below it holds all ones. For example, 0x0FF steps to 0x100 in a single edge.
- R9: Counting from all ones wraps to zero, and `carry_out` falls in the same cycle.
- R10: With `MOD_EN` set, `load_n` high and both enables high, an edge at which `count` equals `MOD_TERM` loads `MOD_PRESET` instead of incrementing. A low `load_n` still takes `load_val`.
- R11: Any value from zero to all ones can be preset, and counting continues upward from that preset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared rising-edge clock |
| wipe_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | WIDTH | Parallel preset value |
| run_en | input | 1 | Count enable shared by all stages |
| chain_en | input | 1 | Count enable into the lowest stage; it also gates the carry |
| count | output | WIDTH | Counter value (STAGES x 4 bits) |
| carry_out | output | 1 | Terminal carry of the top stage |

## Verification
Load, increment, hold and modulo reload all take effect at the rising edge after the inputs are set. The bench changes inputs one nanosecond after an edge and reads `count` one nanosecond after the following edge, so each result is compared exactly one edge after its stimulus.

The clear and the carry go through no register. The bench therefore reads them in the same cycle as their stimulus: the clear is dropped mid-cycle and read before any edge, and the carry is read right after the count it depends on settles.

Mid-cycle pulses on the load and enable inputs are read back before the next edge, which shows that the count did not move.

// File: rtl/cnt_pkg.sv
// Package: shared constants and the stage operation type for the counter chain.
// Assumes: every stage is one nibble wide; the chain width is a multiple of it.
package cnt_pkg;

    localparam int NIB = 4;

    // Operation a stage performs at the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } stage_op_t;

endpackage

// File: rtl/cnt_op_decode.sv
// Module: cnt_op_decode
// Purpose: turns the load and enable levels of one stage into a single operation.
// Assumes: load_n is active low and outranks both enables; clear is handled in the stage.
module cnt_op_decode (
    input  logic                load_n,
    input  logic                run_en,
    input  logic                chain_en,
    output cnt_pkg::stage_op_t  op
);
    import cnt_pkg::*;

    // Priority: load, then step when both enables are high, else hold.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (run_en && chain_en) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_stage.sv
// Module: cnt_stage
// Purpose: one nibble of the counter, holding its state register and its carry output.
// Assumes: op comes from cnt_op_decode; wipe_n clears asynchronously; carry is combinational.
module cnt_stage #(
    parameter int NB = cnt_pkg::NIB
) (
    input  logic                clk,
    input  logic                wipe_n,
    input  cnt_pkg::stage_op_t  op,
    input  logic [NB-1:0]       din,
    input  logic                chain_en,
    output logic [NB-1:0]       q,
    output logic                carry
);
    import cnt_pkg::*;

    logic [NB-1:0] q_r;

    // State register: async clear, then load, step or hold on the rising edge.
    always_ff @(posedge clk or negedge wipe_n) begin
        if (!wipe_n) begin
            q_r <= '0;
        end else begin
            unique case (op)
                OP_LOAD: q_r <= din;
                OP_STEP: q_r <= q_r + 1'b1;
                default: q_r <= q_r;
            endcase
        end
    end

    // Carry look-ahead: only the chain enable gates it, never the shared enable.
    assign carry = chain_en & (&q_r);
    assign q     = q_r;

endmodule

// File: rtl/cnt_mod_ctl.sv
// Module: cnt_mod_ctl
// Purpose: optional range limiter that forces a load of PRESET when the count hits TERM.
// Assumes: the user load always wins; with MOD_EN clear it passes load straight through.
module cnt_mod_ctl #(
    parameter int          WIDTH  = 12,
    parameter bit          MOD_EN = 1'b0,
    parameter int unsigned PRESET = 0,
    parameter int unsigned TERM   = 0
) (
    input  logic [WIDTH-1:0] count,
    input  logic             load_n,
    input  logic [WIDTH-1:0] load_val,
    input  logic             run_en,
    input  logic             chain_en,
    output logic             eff_load_n,
    output logic [WIDTH-1:0] eff_val
);
    localparam logic [WIDTH-1:0] PRESET_V = WIDTH'(PRESET);
    localparam logic [WIDTH-1:0] TERM_V   = WIDTH'(TERM);

    logic at_term;
    logic force_ld;

    // Terminal detect: counting at the terminal value triggers a preset reload.
    always_comb begin
        at_term  = (count == TERM_V);
        force_ld = MOD_EN && at_term && run_en && chain_en && load_n;
    end

    // Load steering: the user value while load_n is low, otherwise the preset.
    always_comb begin
        eff_load_n = load_n & ~force_ld;
        eff_val    = load_n ? PRESET_V : load_val;
    end

endmodule

// File: rtl/cnt_chain.sv
// Module: cnt_chain
// Purpose: chains STAGES counter nibbles into one synchronous counter on a shared clock.
// Assumes: each stage's carry feeds the next stage's chain enable; run_en goes to every stage.
module cnt_chain #(
    parameter  int          STAGES     = 3,
    parameter  bit          MOD_EN     = 1'b0,
    parameter  int unsigned MOD_PRESET = 0,
    parameter  int unsigned MOD_TERM   = 0,
    localparam int          WIDTH      = STAGES * cnt_pkg::NIB
) (
    input  logic             clk,
    input  logic             wipe_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] load_val,
    input  logic             run_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    import cnt_pkg::*;

    localparam int NB = cnt_pkg::NIB;

    logic             eff_load_n;
    logic [WIDTH-1:0] eff_val;
    logic [STAGES:0]  link;
    logic [WIDTH-1:0] q_all;

    cnt_mod_ctl #(
        .WIDTH (WIDTH),
        .MOD_EN(MOD_EN),
        .PRESET(MOD_PRESET),
        .TERM  (MOD_TERM)
    ) mod_i (
        .count     (q_all),
        .load_n    (load_n),
        .load_val  (load_val),
        .run_en    (run_en),
        .chain_en  (chain_en),
        .eff_load_n(eff_load_n),
        .eff_val   (eff_val)
    );

    assign link[0] = chain_en;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        stage_op_t op;

        cnt_op_decode dec_i (
            .load_n  (eff_load_n),
            .run_en  (run_en),
            .chain_en(link[g]),
            .op      (op)
        );

        cnt_stage #(.NB(NB)) stg_i (
            .clk     (clk),
            .wipe_n  (wipe_n),
            .op      (op),
            .din     (eff_val[g*NB +: NB]),
            .chain_en(link[g]),
            .q       (q_all[g*NB +: NB]),
            .carry   (link[g+1])
        );
    end

    assign count     = q_all;
    assign carry_out = link[STAGES];

endmodule

// File: rtl/cnt_chain_chk.sv
// Module: cnt_chain_chk
// Purpose: temporal checks on the counter chain ports, bound to every cnt_chain instance.
// Assumes: the parameters match the bound instance.
module cnt_chain_chk #(
    parameter int          WIDTH      = 12,
    parameter bit          MOD_EN     = 1'b0,
    parameter int unsigned MOD_PRESET = 0,
    parameter int unsigned MOD_TERM   = 0
) (
    input logic             clk,
    input logic             wipe_n,
    input logic             load_n,
    input logic [WIDTH-1:0] load_val,
    input logic             run_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);
    logic at_term;
    assign at_term = MOD_EN && (count == WIDTH'(MOD_TERM));

    // R1: clear holds the count at zero on every edge it is low.
    p_clear_zero_r1: assert property (@(posedge clk)
        !wipe_n |-> (count == '0));

    // R2: a low load takes the parallel value at the next edge.
    p_load_takes_r2: assert property (@(posedge clk) disable iff (!wipe_n)
        !load_n |=> (count == $past(load_val)));

    // R3: both enables high, no load, no terminal: the count advances by one.
    p_step_one_r3: assert property (@(posedge clk) disable iff (!wipe_n)
        (load_n && run_en && chain_en && !at_term) |=> (count == WIDTH'($past(count) + 1'b1)));

    // R4: either enable low with no load keeps the count.
    p_hold_r4: assert property (@(posedge clk) disable iff (!wipe_n)
        (load_n && !(run_en && chain_en)) |=> $stable(count));

    // R5: the terminal carry matches the chain enable and an all-ones count.
    p_carry_match_r5: assert property (@(posedge clk) disable iff (!wipe_n)
        carry_out == (chain_en && (&count)));

    // R10: counting at the terminal value reloads the preset.
    p_mod_reload_r10: assert property (@(posedge clk) disable iff (!wipe_n)
        (load_n && run_en && chain_en && at_term) |=> (count == WIDTH'(MOD_PRESET)));

endmodule

bind cnt_chain cnt_chain_chk #(
    .WIDTH     (WIDTH),
    .MOD_EN    (MOD_EN),
    .MOD_PRESET(MOD_PRESET),
    .MOD_TERM  (MOD_TERM)
) chk_i (
    .clk      (clk),
    .wipe_n   (wipe_n),
    .load_n   (load_n),
    .load_val (load_val),
    .run_en   (run_en),
    .chain_en (chain_en),
    .count    (count),
    .carry_out(carry_out)
);

// File: tb/cnt_chain_tb_top.sv
// Bench for cnt_chain: a full sweep of a 12-bit chain plus a modulo-configured 8-bit chain.
module cnt_chain_tb_top;

    localparam int W  = 12;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          wipe_n;
    logic          load_n, run_en, chain_en;
    logic [W-1:0]  load_val;
    logic [W-1:0]  count;
    logic          carry_out;

    logic          m_load_n, m_run, m_chain;
    logic [MW-1:0] m_val;
    logic [MW-1:0] m_count;
    logic          m_carry;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cnt_chain #(.STAGES(3)) dut_i (
        .clk(clk), .wipe_n(wipe_n), .load_n(load_n), .load_val(load_val),
        .run_en(run_en), .chain_en(chain_en), .count(count), .carry_out(carry_out)
    );

    cnt_chain #(.STAGES(2), .MOD_EN(1'b1), .MOD_PRESET(20), .MOD_TERM(45)) dut_mod_i (
        .clk(clk), .wipe_n(wipe_n), .load_n(m_load_n), .load_val(m_val),
        .run_en(m_run), .chain_en(m_chain), .count(m_count), .carry_out(m_carry)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to 1 ns after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0]  e;
        logic [MW-1:0] me;
        wipe_n = 1'b1; load_n = 1'b1; run_en = 1'b1; chain_en = 1'b1; load_val = '0;
        m_load_n = 1'b1; m_run = 1'b0; m_chain = 1'b0; m_val = '0;
        #2 wipe_n = 1'b0;
        tick();
        check("R1 reset count", 32'(count), 32'h0);
        check("R1 reset carry", 32'(carry_out), 32'h0);
        check("R1 reset mod count", 32'(m_count), 32'h0);
        wipe_n = 1'b1;

        // R2 R11 R3 R8 R9 R5: load every value under varied enables, then one step.
        for (int v = 0; v < (1 << W); v++) begin
            load_n = 1'b0; load_val = W'(v); run_en = v[0]; chain_en = v[1];
            tick();
            check("R2 load", 32'(count), 32'(v));
            check("R5 carry after load", 32'(carry_out), 32'(v[1] && v == (1 << W) - 1));
            load_n = 1'b1; run_en = 1'b1; chain_en = 1'b1;
            tick();
            e = W'(v + 1);
            check("R3 R8 R9 R11 step", 32'(count), 32'(e));
            check("R5 R9 carry after step", 32'(carry_out), 32'(e == {W{1'b1}}));
        end

        // R4: hold with either enable low.
        load_n = 1'b0; load_val = 12'h0FF; tick();
        load_n = 1'b1; run_en = 1'b0; chain_en = 1'b1; tick();
        check("R4 hold run low", 32'(count), 32'h0FF);
        run_en = 1'b1; chain_en = 1'b0; tick();
        check("R4 hold chain low", 32'(count), 32'h0FF);
        check("R5 carry chain low", 32'(carry_out), 32'h0);
        chain_en = 1'b1; tick();
        check("R8 cascade 0FF to 100", 32'(count), 32'h100);

        // R6: run_en low does not gate the carry.
        load_n = 1'b0; load_val = 12'hFFF; tick();
        load_n = 1'b1; run_en = 1'b0; chain_en = 1'b1; #2;
        check("R6 carry with run low", 32'(carry_out), 32'h1);
        chain_en = 1'b0; #1;
        check("R5 carry drops with chain", 32'(carry_out), 32'h0);

        // R7: mid-cycle pulses do not touch the count.
        load_n = 1'b0; load_val = 12'h123; tick();
        load_n = 1'b1; run_en = 1'b0; chain_en = 1'b0;
        load_n = 1'b0; load_val = 12'hABC; #2;
        load_n = 1'b1; run_en = 1'b1; chain_en = 1'b1; #1;
        run_en = 1'b0; #1;
        check("R7 no change between edges", 32'(count), 32'h123);
        run_en = 1'b1; tick();
        check("R7 edge decides", 32'(count), 32'h124);

        // R1: asynchronous clear mid-cycle, and dominance over load.
        wipe_n = 1'b0; #1;
        check("R1 async clear", 32'(count), 32'h0);
        load_n = 1'b0; load_val = 12'h555; tick();
        check("R1 clear beats load", 32'(count), 32'h0);
        wipe_n = 1'b1; tick();
        check("R2 load after clear", 32'(count), 32'h555);
        load_n = 1'b1;

        // R10: modulo chain ranges 20..45.
        m_load_n = 1'b0; m_val = 8'd40; tick();
        check("R10 mod preload", 32'(m_count), 32'd40);
        m_load_n = 1'b1; m_run = 1'b1; m_chain = 1'b1;
        me = 8'd40;
        for (int i = 0; i < 60; i++) begin
            tick();
            me = (me == 8'd45) ? 8'd20 : me + 8'd1;
            check("R10 mod sequence", 32'(m_count), 32'(me));
        end
        m_load_n = 1'b0; m_val = 8'd45; tick();
        m_val = 8'd7; tick();
        check("R10 user load beats reload", 32'(m_count), 32'd7);
        m_load_n = 1'b1; tick();
        check("R10 count resumes", 32'(m_count), 32'd8);
        check("R5 mod carry low", 32'(m_carry), 32'h0);

        finish_run();
    end

endmodule